// File: doc/BRIEF.md
# Scatter Accumulator with Dump-Erase

The block keeps one running sum per output pixel in an on-chip RAM. A stream of samples, each a value paired with a target pixel address, is added into the stored sums. Each RAM read or write takes one cycle. The value of a sample enters five cycles (parameter `ALIGN_LAT`) before its address. This gives an upstream address calculator time to produce the address, and an internal delay line realigns the two. Samples that hit the same address back to back are merged in a side accumulator. The RAM is written only when the address changes, so a read-modify-write never sees a stale word.

A one-cycle `dump_req` pulse ends a frame. The pending run is written to RAM first. The block then reads every location in ascending order on `out_data`/`out_valid` and writes zero into each location in the same cycle, so the next frame starts from a clean RAM. `out_finish` marks the last word. One instance per colour channel holds pixel sums. A narrower instance, with its value input tied to 1, holds contribution counts.

After reset the block spends `DEPTH` cycles zeroing the RAM, and no samples may arrive during that time. A `dump_req` must come no earlier than the cycle after the last sample's address.

Top module: `scatter_accum`

## Requirements
- R1: After reset `out_valid` and `out_finish` are low, and a dump with no samples since reset returns zero at every address.
- R2: A sample is formed from `in_data`/`in_valid` at cycle t and `in_addr` at cycle t+`ALIGN_LAT` (5 by default).
- R3: The word dumped for address k equals the sum of all sample values aimed at k since the previous dump, or since reset.
- R4: Any number of consecutive samples to one address, including runs with idle cycles between them, are summed without loss.
- R5: Addresses that alternate every cycle (A, B, A, B) are summed correctly.
- R6: The run still pending when `dump_req` arrives is included in that dump.
- R7: A dump outputs exactly `DEPTH` words on consecutive cycles, address 0 first and ascending. The first word is valid two cycles after the clock edge that samples `dump_req`.
- R8: `out_finish` is a one-cycle pulse that is high together with the word for address `DEPTH-1`, and never at other times.
- R9: Each location is zeroed as it is dumped, so a dump that directly follows another with no samples between returns all zeros.
- R10: Samples whose address arrives while a dump is in progress are dropped, and a `dump_req` raised during a dump is ignored.
- R11: The sum width is `DATA_W + clog2(MAX_HITS)`. `MAX_HITS` samples of the largest value into one address are reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_addr | input | ADDR_W | Target pixel address, `ALIGN_LAT` cycles after its value |
| in_data | input | DATA_W | Sample value |
| in_valid | input | 1 | Sample value present (same cycle as `in_data`) |
| dump_req | input | 1 | One-cycle pulse that ends the frame and starts the dump |
| out_data | output | SUM_W | Dumped sum |
| out_valid | output | 1 | `out_data` holds a dumped word |
| out_finish | output | 1 | High with the last dumped word |

## Verification
The bench targets long runs of maximum values to one pixel. A design with a narrow sum or a broken run merge would drop the carry or lose all but one sample. It also targets alternating addresses and runs broken by idle cycles, where a write that reads a stale RAM word would lose contributions. A run left pending at `dump_req` is checked, because a missing flush drops the last pixel. So is a wrong lag between value and address, which moves sums to other pixels. Junk samples and a second `dump_req` are sent during a dump, and the following dump must read all zeros. A design that did not erase, or that accepted samples mid-dump, would leak values into the next frame.

// File: rtl/scatter_accum_pkg.sv
`timescale 1ns/1ps
// Shared types for the scatter accumulator.
package scatter_accum_pkg;
    // Phases of the controller: initial clear, accumulate, drain pending write, dump
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ACC   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DUMP  = 2'd3
    } sacc_state_e;
endpackage

// File: rtl/sacc_delay_line.sv
`timescale 1ns/1ps
// Delays a value and its valid flag by STAGES cycles so that the value
// lines up with an address that arrives later.
// Assumes STAGES >= 1.
module sacc_delay_line #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [WIDTH-1:0] in_d,
    output logic             out_v,
    output logic [WIDTH-1:0] out_d
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic             v_q;
        logic [WIDTH-1:0] d_q;
        logic             v_src;
        logic [WIDTH-1:0] d_src;
        if (g == 0) begin : g_head
            assign v_src = in_v;
            assign d_src = in_d;
        end else begin : g_body
            assign v_src = g_stage[g-1].v_q;
            assign d_src = g_stage[g-1].d_q;
        end
        // One register stage of the delay line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                v_q <= v_src;
                d_q <= d_src;
            end
        end
    end

    assign out_v = g_stage[STAGES-1].v_q;
    assign out_d = g_stage[STAGES-1].d_q;
endmodule

// File: rtl/sacc_run_merge.sv
`timescale 1ns/1ps
// Merges back-to-back samples aimed at the same address into one pending
// run sum. A run is closed (handed out for a RAM update) when a sample
// with a different address is taken, or when flush is raised.
// Assumes take and flush are never high together.
module sacc_run_merge #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SUM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    output logic              close_valid,
    output logic [ADDR_W-1:0] close_addr,
    output logic [SUM_W-1:0]  close_sum
);
    logic              run_valid;
    logic [ADDR_W-1:0] run_addr;
    logic [SUM_W-1:0]  run_sum;
    logic              same_addr;

    assign same_addr   = run_valid && (smp_addr == run_addr);
    assign close_valid = run_valid && (flush || (take && !same_addr));
    assign close_addr  = run_addr;
    assign close_sum   = run_sum;

    // Extend the pending run or start a new one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_valid <= 1'b0;
            run_addr  <= '0;
            run_sum   <= '0;
        end else if (flush) begin
            run_valid <= 1'b0;
        end else if (take) begin
            if (same_addr) begin
                run_sum <= run_sum + SUM_W'(smp_data);
            end else begin
                run_valid <= 1'b1;
                run_addr  <= smp_addr;
                run_sum   <= SUM_W'(smp_data);
            end
        end
    end

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && same_addr) |=> (run_valid && $stable(run_addr))); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !run_valid); // R6
endmodule

// File: rtl/sacc_ram.sv
`timescale 1ns/1ps
// Simple dual-port RAM with one synchronous read port and one write port.
// A read and a write to the same address on the same edge return the old word.
module sacc_ram #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 12,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Registered read and write of the storage array
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/scatter_accum.sv
`timescale 1ns/1ps
// Per-pixel scatter accumulator with a dump phase that reads out and erases.
// Samples whose value arrives ALIGN_LAT cycles before the address are
// realigned, same-address runs are merged, and each closed run is added
// to RAM with a one-cycle read-modify-write. dump_req flushes the pending
// run, drains its write, then streams all DEPTH words in ascending order
// while writing zero into each one.
// Assumes: no samples during the DEPTH-cycle clear after reset; dump_req
// arrives no earlier than the cycle after the last sample address; at most
// MAX_HITS samples per pixel per frame.
module scatter_accum
    import scatter_accum_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int DATA_W    = 8,
    parameter int MAX_HITS  = 16,
    parameter int ALIGN_LAT = 5,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int SUM_W    = DATA_W + $clog2(MAX_HITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              dump_req,
    output logic [SUM_W-1:0]  out_data,
    output logic              out_valid,
    output logic              out_finish
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    sacc_state_e       state;
    logic [ADDR_W-1:0] sweep_cnt;
    logic              al_valid;
    logic [DATA_W-1:0] al_data;
    logic              take;
    logic              flush;
    logic              close_valid;
    logic [ADDR_W-1:0] close_addr;
    logic [SUM_W-1:0]  close_sum;
    logic              cm_valid;
    logic [ADDR_W-1:0] cm_addr;
    logic [SUM_W-1:0]  cm_sum;
    logic [SUM_W-1:0]  ram_q;
    logic [SUM_W:0]    merged;
    logic              sweeping;
    logic [ADDR_W-1:0] ram_ra;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_wa;
    logic [SUM_W-1:0]  ram_wd;

    sacc_delay_line #(.WIDTH(DATA_W), .STAGES(ALIGN_LAT)) u_align (
        .clk(clk), .rst_n(rst_n),
        .in_v(in_valid), .in_d(in_data),
        .out_v(al_valid), .out_d(al_data)
    );

    assign take  = al_valid && (state == ST_ACC) && !dump_req;
    assign flush = (state == ST_ACC) && dump_req;

    sacc_run_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .take(take), .flush(flush),
        .smp_addr(in_addr), .smp_data(al_data),
        .close_valid(close_valid), .close_addr(close_addr), .close_sum(close_sum)
    );

    // Hold the closed run for its write cycle, one cycle after the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_valid <= 1'b0;
            cm_addr  <= '0;
            cm_sum   <= '0;
        end else begin
            cm_valid <= close_valid;
            cm_addr  <= close_addr;
            cm_sum   <= close_sum;
        end
    end

    assign merged   = {1'b0, ram_q} + {1'b0, cm_sum};
    assign sweeping = (state == ST_DUMP) || (state == ST_CLEAR);

    // Port selection between accumulate mode and sweep (clear or dump) mode
    always_comb begin
        if (sweeping) begin
            ram_ra = sweep_cnt;
            ram_we = 1'b1;
            ram_wa = sweep_cnt;
            ram_wd = '0;
        end else begin
            ram_ra = close_addr;
            ram_we = cm_valid;
            ram_wa = cm_addr;
            ram_wd = merged[SUM_W-1:0];
        end
    end

    sacc_ram #(.DEPTH(DEPTH), .WIDTH(SUM_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk),
        .rd_addr(ram_ra), .rd_data(ram_q),
        .wr_en(ram_we), .wr_addr(ram_wa), .wr_data(ram_wd)
    );

    // Phase controller and sweep address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CLEAR;
            sweep_cnt <= '0;
        end else begin
            case (state)
                ST_CLEAR: begin
                    sweep_cnt <= sweep_cnt + 1'b1;
                    if (sweep_cnt == LAST_ADDR) begin
                        state     <= ST_ACC;
                        sweep_cnt <= '0;
                    end
                end
                ST_ACC: begin
                    if (dump_req) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    state     <= ST_DUMP;
                    sweep_cnt <= '0;
                end
                default: begin
                    sweep_cnt <= sweep_cnt + 1'b1;
                    if (sweep_cnt == LAST_ADDR) begin
                        state     <= ST_ACC;
                        sweep_cnt <= '0;
                    end
                end
            endcase
        end
    end

    // Output flags follow the dump read by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_finish <= 1'b0;
        end else begin
            out_valid  <= (state == ST_DUMP);
            out_finish <= (state == ST_DUMP) && (sweep_cnt == LAST_ADDR);
        end
    end

    assign out_data = ram_q;

    AST_DUMP_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMP && $past(state) == ST_DUMP) |-> (sweep_cnt == ADDR_W'($past(sweep_cnt) + 1'b1))); // R7
    AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> ($past(state) == ST_ACC && $past(dump_req))); // R7
    AST_FINISH_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_finish |-> out_valid); // R8
    AST_FINISH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_finish |=> !out_finish); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweeping && cm_valid) |-> !merged[SUM_W]); // R11
endmodule

// File: tb/test_scatter_accum.sv
`timescale 1ns/1ps
module test_scatter_accum;
    localparam int DEPTH     = 64;
    localparam int DATA_W    = 8;
    localparam int MAX_HITS  = 16;
    localparam int ALIGN_LAT = 5;
    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int SUM_W     = DATA_W + $clog2(MAX_HITS);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] in_addr;
    logic [DATA_W-1:0] in_data;
    logic              in_valid;
    logic              dump_req;
    logic [SUM_W-1:0]  out_data;
    logic              out_valid;
    logic              out_finish;

    always #4 clk = ~clk;

    scatter_accum #(.DEPTH(DEPTH), .DATA_W(DATA_W), .MAX_HITS(MAX_HITS), .ALIGN_LAT(ALIGN_LAT))
    i_scatter_accum (
        .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .in_data(in_data),
        .in_valid(in_valid), .dump_req(dump_req), .out_data(out_data),
        .out_valid(out_valid), .out_finish(out_finish)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int exp_sum [DEPTH];
    int hits    [DEPTH];
    int sv [256];
    int sa [256];
    int sd [256];
    int ns;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < DEPTH; i++) begin
            exp_sum[i] = 0;
            hits[i]    = 0;
        end
        ns = 0;
    endtask

    task automatic add_slot(input int v, input int a, input int d);
        sv[ns] = v; sa[ns] = a; sd[ns] = d;
        ns++;
        if (v != 0) begin
            exp_sum[a] += d;
            hits[a]++;
        end
    endtask

    task automatic rand_frame(input int n);
        int prev = 0;
        for (int i = 0; i < n; i++) begin
            int a = (($urandom % 2) == 0) ? prev : int'($urandom % DEPTH);
            int d = int'($urandom % 256);
            int v = (($urandom % 4) != 0) ? 1 : 0;
            if (v != 0 && hits[a] >= MAX_HITS) v = 0;
            add_slot(v, a, d);
            prev = a;
        end
    endtask

    // R2: value at slot i, its address ALIGN_LAT cycles later
    task automatic play();
        for (int i = 0; i < ns + ALIGN_LAT; i++) begin
            @(negedge clk);
            in_valid = (i < ns) ? sv[i][0] : 1'b0;
            in_data  = (i < ns) ? DATA_W'(sd[i]) : DATA_W'($urandom);
            in_addr  = (i >= ALIGN_LAT) ? ADDR_W'(sa[i-ALIGN_LAT]) : ADDR_W'($urandom);
        end
        ns = 0;
    endtask

    task automatic dump_check(input string tag, input bit junk);
        @(negedge clk);
        in_valid = 1'b0;
        dump_req = 1'b1;
        @(negedge clk);
        dump_req = 1'b0;
        chk(out_valid == 1'b0, "R7 no word one cycle after dump_req", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 no word two cycles after dump_req", out_valid, 0);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R7 continuous dump valid", out_valid, 1);
            chk(out_data == SUM_W'(exp_sum[k]), {tag, " sum at ascending address"}, out_data, exp_sum[k]);
            chk(out_finish == (k == DEPTH-1), "R8 finish only with last word", out_finish, (k == DEPTH-1));
            // R10: junk samples and a repeated dump_req during the dump
            in_valid = junk && (k < 20);
            in_data  = DATA_W'($urandom);
            in_addr  = ADDR_W'($urandom);
            dump_req = junk && (k == 10);
        end
        @(negedge clk);
        chk(out_valid == 1'b0 && out_finish == 1'b0, "R7 R8 dump ends after DEPTH words",
            {out_valid, out_finish}, 0);
        in_valid = 1'b0;
        dump_req = 1'b0;
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; in_addr = '0; in_data = '0; in_valid = 1'b0; dump_req = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid low in reset", out_valid, 0);
        chk(out_finish == 1'b0, "R1 out_finish low in reset", out_finish, 0);
        rst_n = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid low after clear", out_valid, 0);
        dump_check("R1 empty after reset", 1'b0);

        // Directed: max run (R11 R4), alternation (R5), gapped run (R4), last run pending (R6)
        for (int i = 0; i < MAX_HITS; i++) add_slot(1, 3, 255);
        add_slot(1, 5, 1); add_slot(1, 6, 2); add_slot(1, 5, 4); add_slot(1, 6, 8); add_slot(1, 5, 16);
        add_slot(1, 10, 9); add_slot(0, 0, 0); add_slot(0, 0, 0); add_slot(1, 10, 11);
        add_slot(1, 0, 33); add_slot(1, 1, 44);
        add_slot(1, 63, 7);
        play();
        dump_check("R2 R3 R4 R5 R6 R11 directed", 1'b1);
        dump_check("R9 R10 erased and junk dropped", 1'b0);

        for (int f = 0; f < 4; f++) begin
            rand_frame(150);
            play();
            dump_check("R3 R4 random frame", f == 1);
        end
        dump_check("R9 R10 erased after random", 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule